// File: doc/BRIEF.md
# PLL Control and Lock Monitor

This block is the register front end of a single PLL channel. A word-addressed register port holds a 32-bit control word and presents a status word. The control word selects one of three operating modes (run, reference pass-through, stopped) and carries three divider codes. The block decodes these codes into the effective input divide, feedback multiply and output divide factors. Each code uses its own encoding: the input code is offset by one, the feedback code is offset by one and then doubled, and the output code is a power-of-two exponent.

The block also models relocking. Every write to the control word drops the lock indication. A counter then runs for a parameterised number of system clock cycles, set to cover the worst-case 100 µs lock time, and lock returns when it expires. When the feedback-to-input ratio leaves a parameterised legal window, an error flag is raised and lock is held low. The analog loop itself is not modelled. Downstream logic reads the decoded factors, the mode and the two status flags from plain output pins. There is no streamed data, so there is no valid/ready handshake.

Top module: `pll_ctrl_monitor`

## Requirements
- R1: Byte offset 0x0 reads back the full 32-bit control word. Offset 0x4 reads the status word, with the lock flag in bit 0, the error flag in bit 1 and zero elsewhere. Offsets 0x8 and 0xC, and every other offset, read as zero. Reads are combinational.
- R2: A write to any offset other than 0x0 changes neither the control word nor the decoded outputs, and it does not restart the relock count.
- R3: In run mode, `in_div` equals the value of control bits [8:4] plus one.
- R4: In run mode, `fb_mul` equals two times the value of control bits [15:9] plus one.
- R5: In run mode, `out_div` equals two raised to the value of control bits [3:2].
- R6: When control bit 1 (bypass) is set, `pll_mode` is 1 (pass-through), regardless of bit 0. All three factor outputs read 1 and `pll_err` is 0, whatever the divider codes hold.
- R7: When bit 0 (power-down) is set and bit 1 is clear, `pll_mode` is 2 (stopped). All three factor outputs read 1, and both `pll_locked` and `pll_err` are 0. When both bits are clear, `pll_mode` is 0 (run).
- R8: A control write clears `pll_locked` from the next cycle. The flag is set again exactly LOCK_CYCLES clock edges after the write edge, provided the new word is legal and the mode is not stopped. A second write during the count restarts it.
- R9: In run mode, `pll_err` is 1 exactly when `fb_mul` < RATIO_MIN·`in_div` or `fb_mul` > RATIO_MAX·`in_div`, with the defaults 4 and 48. While `pll_err` is 1, `pll_locked` is 0.
- R10: After reset, the control word is 0x00000001 (stopped), `pll_locked` is 0 and `pll_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| in_div | output | 6 | Effective input divide factor |
| fb_mul | output | 9 | Effective feedback multiply factor |
| out_div | output | 4 | Effective output divide factor |
| pll_mode | output | 2 | 0 run, 1 pass-through, 2 stopped |
| pll_locked | output | 1 | Lock flag |
| pll_err | output | 1 | Illegal ratio flag |

## Verification
The hardest state to reach from the ports is an overlap: a relock count cut short by a second control write, where lock must then follow the second write and not the first. The stimulus issues a write, waits part of the lock time, writes again, and checks the cycles on both sides of the expected rise. Illegal ratios at both edges of the window are driven next to legal words that sit exactly on each limit. Mode-priority words put illegal divider codes under bypass and power-down.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_BYPASS  = 2'd1,
    MODE_STOPPED = 2'd2
  } pll_mode_e;

  localparam int PD_BIT  = 0;
  localparam int BYP_BIT = 1;
  localparam int OD_LSB  = 2;
  localparam int OD_W    = 2;
  localparam int ID_LSB  = 4;
  localparam int ID_W    = 5;
  localparam int FB_LSB  = 9;
  localparam int FB_W    = 7;
  localparam int CTRL_USED_W = FB_LSB + FB_W;

  localparam int IN_DIV_W  = ID_W + 1;
  localparam int FB_MUL_W  = FB_W + 2;
  localparam int OUT_DIV_W = (1 << OD_W);

  localparam int OFS_CTRL = 'h0;
  localparam int OFS_STAT = 'h4;
  localparam int OFS_MEAS = 'h8;
  localparam int OFS_MON  = 'hC;

  typedef struct packed {
    logic [IN_DIV_W-1:0]  in_div;
    logic [FB_MUL_W-1:0]  fb_mul;
    logic [OUT_DIV_W-1:0] out_div;
    pll_mode_e            mode;
  } pll_cfg_t;
endpackage

// File: rtl/pllc_regs.sv
module pllc_regs
  import pllc_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] CTRL_RST = 32'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              stat_lock,
  input  logic              stat_err,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              ctrl_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic hit_ctrl, hit_stat;

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign ctrl_wr  = bus_wr && hit_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= DATA_W'(CTRL_RST);
    else if (ctrl_wr) ctrl_q <= bus_wdata;
  end

  // Measure, monitor and unmapped offsets fall to the zero default.
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_q;
    else if (hit_stat) bus_rdata = DATA_W'({stat_err, stat_lock});
  end
endmodule

// File: rtl/pllc_decode.sv
module pllc_decode
  import pllc_pkg::*;
#(
  parameter int RATIO_MIN = 4,
  parameter int RATIO_MAX = 48
) (
  input  logic [CTRL_USED_W-1:0] ctrl,
  output pll_cfg_t               cfg,
  output logic                   err
);
  logic [ID_W-1:0]      id_code;
  logic [FB_W-1:0]      fb_code;
  logic [OD_W-1:0]      od_code;
  logic [IN_DIV_W-1:0]  run_in;
  logic [FB_MUL_W-1:0]  run_fb;
  logic [OUT_DIV_W-1:0] run_out;
  logic [31:0]          lo_lim, hi_lim;
  pll_mode_e            mode;

  always_comb begin
    id_code = ctrl[ID_LSB +: ID_W];
    fb_code = ctrl[FB_LSB +: FB_W];
    od_code = ctrl[OD_LSB +: OD_W];
    run_in  = IN_DIV_W'(id_code) + IN_DIV_W'(1);
    run_fb  = FB_MUL_W'({fb_code, 1'b0}) + FB_MUL_W'(2);
    run_out = OUT_DIV_W'(1) << od_code;
    lo_lim  = 32'(RATIO_MIN) * 32'(run_in);
    hi_lim  = 32'(RATIO_MAX) * 32'(run_in);

    if (ctrl[BYP_BIT])     mode = MODE_BYPASS;
    else if (ctrl[PD_BIT]) mode = MODE_STOPPED;
    else                   mode = MODE_RUN;

    cfg.mode = mode;
    if (mode == MODE_RUN) begin
      cfg.in_div  = run_in;
      cfg.fb_mul  = run_fb;
      cfg.out_div = run_out;
      err = (32'(run_fb) < lo_lim) || (32'(run_fb) > hi_lim);
    end else begin
      cfg.in_div  = IN_DIV_W'(1);
      cfg.fb_mul  = FB_MUL_W'(1);
      cfg.out_div = OUT_DIV_W'(1);
      err = 1'b0;
    end
  end
endmodule

// File: rtl/pllc_lock.sv
module pllc_lock #(
  parameter int LOCK_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic settled
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (restart)     cnt <= CNT_W'(LOCK_CYCLES);
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign settled = (cnt == '0);
endmodule

// File: rtl/pll_ctrl_monitor.sv
module pll_ctrl_monitor
  import pllc_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DATA_W      = 32,
  parameter int          LOCK_CYCLES = 20000,
  parameter int          RATIO_MIN   = 4,
  parameter int          RATIO_MAX   = 48,
  parameter logic [31:0] CTRL_RST    = 32'h1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [IN_DIV_W-1:0]  in_div,
  output logic [FB_MUL_W-1:0]  fb_mul,
  output logic [OUT_DIV_W-1:0] out_div,
  output logic [1:0]           pll_mode,
  output logic                 pll_locked,
  output logic                 pll_err
);
  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic              settled;
  pll_cfg_t          cfg;

  pllc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_RST(CTRL_RST)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stat_lock(pll_locked), .stat_err(pll_err),
    .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .bus_rdata(bus_rdata)
  );

  pllc_decode #(.RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)) i_decode (
    .ctrl(ctrl_q[CTRL_USED_W-1:0]), .cfg(cfg), .err(pll_err)
  );

  pllc_lock #(.LOCK_CYCLES(LOCK_CYCLES)) i_lock (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .settled(settled)
  );

  assign in_div     = cfg.in_div;
  assign fb_mul     = cfg.fb_mul;
  assign out_div    = cfg.out_div;
  assign pll_mode   = cfg.mode;
  assign pll_locked = settled && !pll_err && (cfg.mode != MODE_STOPPED);
endmodule

// File: rtl/pllc_checker.sv
module pllc_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [5:0]        in_div,
  input logic [8:0]        fb_mul,
  input logic [3:0]        out_div,
  input logic [1:0]        pll_mode,
  input logic              pll_locked,
  input logic              pll_err
);
  logic wr_ctrl, wr_other;
  assign wr_ctrl  = bus_wr && (bus_addr == '0);
  assign wr_other = bus_wr && (bus_addr != '0);

  a_r8_drop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !pll_locked);
  a_r8_no_rise_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_locked) |-> !$past(wr_ctrl));
  a_r9_err_blocks_lock: assert property (@(posedge clk) disable iff (!rst_n)
    pll_err |-> !pll_locked);
  a_r7_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mode == 2'd2) |-> (!pll_locked && !pll_err));
  a_r6_factors_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mode != 2'd0) |-> (in_div == 6'd1 && fb_mul == 9'd1 && out_div == 4'd1));
  a_r5_out_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_div) && (out_div != 4'd0));
  a_r4_fb_even: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_mode == 2'd0) |-> (fb_mul[0] == 1'b0 && fb_mul >= 9'd2));
  a_r2_other_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> ($stable(pll_mode) && $stable(in_div) && $stable(fb_mul) && $stable(out_div)));
endmodule

bind pll_ctrl_monitor pllc_checker #(.ADDR_W(ADDR_W)) i_pllc_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .in_div(in_div), .fb_mul(fb_mul), .out_div(out_div), .pll_mode(pll_mode),
  .pll_locked(pll_locked), .pll_err(pll_err)
);

// File: tb/test_pll_ctrl_monitor.sv
module test_pll_ctrl_monitor;
  localparam int L = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  in_div;
  logic [8:0]  fb_mul;
  logic [3:0]  out_div;
  logic [1:0]  pll_mode;
  logic        pll_locked, pll_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pll_ctrl_monitor #(.LOCK_CYCLES(L)) i_pll_ctrl_monitor (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_div(in_div),
    .fb_mul(fb_mul), .out_div(out_div), .pll_mode(pll_mode),
    .pll_locked(pll_locked), .pll_err(pll_err)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [5:0]  ind;
    logic [8:0]  fbm;
    logic [3:0]  outd;
    logic [1:0]  mode;
    logic        err;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{32'h0000160C, 6'd1,  9'd24,  4'd8, 2'd0, 1'b0},
    '{32'h00005E18, 6'd2,  9'd96,  4'd4, 2'd0, 1'b0},
    '{32'h00000200, 6'd1,  9'd4,   4'd1, 2'd0, 1'b0},
    '{32'h00000004, 6'd1,  9'd2,   4'd2, 2'd0, 1'b1},
    '{32'h00003000, 6'd1,  9'd50,  4'd1, 2'd0, 1'b1},
    '{32'h0000FFFC, 6'd32, 9'd256, 4'd8, 2'd0, 1'b0},
    '{32'h00000006, 6'd1,  9'd1,   4'd1, 2'd1, 1'b0},
    '{32'h00000003, 6'd1,  9'd1,   4'd1, 2'd1, 1'b0},
    '{32'h0000160D, 6'd1,  9'd1,   4'd1, 2'd2, 1'b0},
    '{32'h000000A0, 6'd11, 9'd2,   4'd1, 2'd0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    // R10 reset state
    rd(8'h00, d); check("R10 ctrl reset", d, 32'h1);
    check("R10 mode", 32'(pll_mode), 32'd2);
    check("R10 lock", 32'(pll_locked), 0);
    check("R10 err", 32'(pll_err), 0);
    rst_n = 1'b1;
    idle(2);

    // Vector walk: R3 R4 R5 R6 R7 R9 R8 R1
    for (int v = 0; v < 10; v++) begin
      wr(8'h00, VECS[v].ctrl);
      check("R3 in_div", 32'(in_div), 32'(VECS[v].ind));
      check("R4 fb_mul", 32'(fb_mul), 32'(VECS[v].fbm));
      check("R5 out_div", 32'(out_div), 32'(VECS[v].outd));
      check("R6/R7 mode", 32'(pll_mode), 32'(VECS[v].mode));
      check("R9 err", 32'(pll_err), 32'(VECS[v].err));
      check("R8 lock dropped", 32'(pll_locked), 0);
      idle(L + 1);
      check("R8 lock after relock", 32'(pll_locked),
            32'(!VECS[v].err && VECS[v].mode != 2'd2));
      rd(8'h04, d);
      check("R1 status word", d, {30'd0, VECS[v].err, !VECS[v].err && VECS[v].mode != 2'd2});
      rd(8'h00, d); check("R1 ctrl readback", d, VECS[v].ctrl);
    end

    // R8 exact timing
    wr(8'h00, 32'h0000160C);
    idle(L - 1);
    check("R8 still unlocked at L-1", 32'(pll_locked), 0);
    idle(1);
    check("R8 locked at L", 32'(pll_locked), 1);

    // R8 restart during count
    wr(8'h00, 32'h00005E18);
    idle(L / 2);
    wr(8'h00, 32'h0000160C);
    idle(L - 1);
    check("R8 restart holds lock low", 32'(pll_locked), 0);
    idle(1);
    check("R8 restart lock at L", 32'(pll_locked), 1);

    // R2 writes elsewhere ignored
    wr(8'h04, 32'hFFFFFFFF);
    check("R2 status write no relock", 32'(pll_locked), 1);
    wr(8'h08, 32'h00000003);
    wr(8'h0C, 32'h00000001);
    wr(8'h40, 32'h00000002);
    check("R2 lock kept", 32'(pll_locked), 1);
    check("R2 mode kept", 32'(pll_mode), 0);
    check("R2 fb kept", 32'(fb_mul), 24);
    rd(8'h00, d); check("R2 ctrl kept", d, 32'h0000160C);

    // R1 zero-reading offsets
    rd(8'h08, d); check("R1 measure reads zero", d, 0);
    rd(8'h0C, d); check("R1 monitor reads zero", d, 0);
    rd(8'h10, d); check("R1 unmapped reads zero", d, 0);

    // R9 then legal word recovers lock
    wr(8'h00, 32'h00000004);
    idle(L + 2);
    check("R9 err holds lock low", 32'(pll_locked), 0);
    wr(8'h00, 32'h00000200);
    idle(L + 1);
    check("R9 recovered lock", 32'(pll_locked), 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule